// File: doc/BRIEF.md
# Bit-Swapping Low-Power LFSR Pattern Generator

This block produces pseudo-random test vectors for logic self-test. Its core is an n-bit maximal-length linear feedback shift register in the internal (Galois) form. Between that register and the output bus sits a row of 2:1 multiplexers that exchange neighbouring bit pairs whenever the top cell holds 0. The output bus therefore toggles less often than the raw register does. Over one period it still carries every non-zero vector exactly once, only in a different order.

A test controller releases reset, optionally loads a seed, and holds the enable high while the circuit under test consumes one vector per clock. The raw register state is also brought out so that a checker can follow the sequence. Width, tap polynomial and reset value are parameters. The default is a 16-bit register with the primitive polynomial x^16+x^14+x^13+x^11+1.

Top module: `bs_lfsr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes INIT (default 16'hACE1), and `pat_o` becomes the swapped image of INIT defined in R6/R7.
- R2: When `en` is high and `load` is low, the next state is {state[W-2:0],0} XOR (state[W-1] ? TAPS : 0), with TAPS default 16'h6801. Bit 0 takes the old top bit.
- R3: When `en` and `load` are both low, neither `state_o` nor `pat_o` changes.
- R4: When `load` is high, the next state is `seed`, whatever the value of `en`.
- R5: A load with an all-zero `seed` places INIT in the register instead, so the state is never zero.
- R6: When state bit W-1 is 0, `pat_o` bits 2k and 2k+1 are exchanged for every k with 2k+1 < W-1. Bit W-1 passes through unchanged. With an even W, bit W-2 is unpaired and also passes through unchanged.
- R7: When state bit W-1 is 1, `pat_o` equals `state_o`. `pat_o` and `state_o` are both registered and are updated on the same edge.
- R8: With `en` held high, the state returns to its starting value after exactly 2^W-1 clocks and not before.
- R9: Over one period, `pat_o` takes every non-zero W-bit value exactly once and never takes zero.
- R10: Over one full period, the number of bit toggles on `pat_o` is strictly smaller than the number of bit toggles on `state_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Load `seed` (has priority over `en`) |
| seed | input | WIDTH | Seed value; zero is replaced by INIT |
| pat_o | output | WIDTH | Bit-swapped test pattern |
| state_o | output | WIDTH | Raw register state |

## Verification
The bench follows a full 65535-step period of the 16-bit instance. A wrong tap mask, or a register that shifts the wrong way, shows up there as a period that is too short and as mismatches against the step model. A second 8-bit instance is checked for exhaustive coverage. A swap network that paired the wrong bits, or that swapped the select bit itself, would repeat or skip vectors on that instance and would fail the pairing checks. Directed cases load an all-zero seed and apply load together with enable. A design lacking seed substitution would lock at zero, and one with the wrong priority would advance instead of loading. A toggle comparison over the full period shows whether the swap polarity is correct. Inverting the polarity leaves the vector set unchanged but breaks the per-cycle model check.

// File: rtl/bs_lfsr_pkg.sv
package bs_lfsr_pkg;

  // Register action chosen for the coming clock edge.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADV  = 2'd1,
    STEP_LOAD = 2'd2
  } step_e;

endpackage

// File: rtl/bs_lfsr_ctrl.sv
module bs_lfsr_ctrl
  import bs_lfsr_pkg::*;
#(
  parameter int               WIDTH = 16,
  parameter logic [WIDTH-1:0] INIT  = 16'hACE1
) (
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output step_e            op,
  output logic [WIDTH-1:0] load_val
);

  // Load wins over advance; an all-zero seed would lock the register.
  always_comb begin
    if (load)    op = STEP_LOAD;
    else if (en) op = STEP_ADV;
    else         op = STEP_HOLD;
  end

  assign load_val = (seed == '0) ? INIT : seed;

endmodule

// File: rtl/bs_lfsr_core.sv
module bs_lfsr_core
  import bs_lfsr_pkg::*;
#(
  parameter int               WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS  = 16'h6801,
  parameter logic [WIDTH-1:0] INIT  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  step_e            op,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] state_q,
  output logic [WIDTH-1:0] state_d
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] adv;

  // Internal-form feedback: top cell wraps to cell 0 and is XORed into tapped cells.
  assign adv[0] = state_q[MSB];
  for (genvar i = 1; i < WIDTH; i++) begin : g_cell
    assign adv[i] = state_q[i-1] ^ (TAPS[i] & state_q[MSB]);
  end

  always_comb begin
    case (op)
      STEP_ADV:  state_d = adv;
      STEP_LOAD: state_d = load_val;
      default:   state_d = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= INIT;
    else     state_q <= state_d;
  end

  // R2
  adv_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (op == STEP_ADV) |=> (state_q[0] == $past(state_q[MSB])));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (op == STEP_HOLD) |=> $stable(state_q));

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    (op == STEP_LOAD) |=> (state_q == $past(load_val)));

  // R5
  never_zero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/bs_swap_net.sv
module bs_swap_net #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int NPAIRS = (WIDTH - 1) / 2;

  logic pass;
  assign pass = din[WIDTH-1];

  // Neighbouring pairs exchange when the top cell is 0.
  for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
    assign dout[2*k]   = pass ? din[2*k]   : din[2*k+1];
    assign dout[2*k+1] = pass ? din[2*k+1] : din[2*k];
  end

  // Even width leaves the cell just below the select without a partner.
  if (2 * NPAIRS < WIDTH - 1) begin : g_lone
    assign dout[WIDTH-2] = din[WIDTH-2];
  end

  assign dout[WIDTH-1] = din[WIDTH-1];

endmodule

// File: rtl/bs_lfsr_gen.sv
module bs_lfsr_gen
  import bs_lfsr_pkg::*;
#(
  parameter int               WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS  = 16'h6801,
  parameter logic [WIDTH-1:0] INIT  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] pat_o,
  output logic [WIDTH-1:0] state_o
);

  step_e            op;
  logic [WIDTH-1:0] load_val;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] pat_d;
  logic [WIDTH-1:0] pat_init;
  logic [WIDTH-1:0] pat_q;

  bs_lfsr_ctrl #(.WIDTH(WIDTH), .INIT(INIT)) u_ctrl (
    .en       (en),
    .load     (load),
    .seed     (seed),
    .op       (op),
    .load_val (load_val)
  );

  bs_lfsr_core #(.WIDTH(WIDTH), .TAPS(TAPS), .INIT(INIT)) u_core (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (load_val),
    .state_q  (state_q),
    .state_d  (state_d)
  );

  // Swap the value the register is about to take, so the pattern
  // register stays aligned with the state register.
  bs_swap_net #(.WIDTH(WIDTH)) u_swap_next (
    .din  (state_d),
    .dout (pat_d)
  );

  bs_swap_net #(.WIDTH(WIDTH)) u_swap_init (
    .din  (INIT),
    .dout (pat_init)
  );

  always_ff @(posedge clk) begin
    if (rst) pat_q <= pat_init;
    else     pat_q <= pat_d;
  end

  assign pat_o   = pat_q;
  assign state_o = state_q;

  // R6
  select_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (pat_o[WIDTH-1] == state_o[WIDTH-1]) &&
    ($countones(pat_o) == $countones(state_o)));

  // R6
  low_pair_swap_chk: assert property (@(posedge clk) disable iff (rst)
    !state_o[WIDTH-1] |-> (pat_o[1:0] == {state_o[0], state_o[1]}));

  // R7
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    state_o[WIDTH-1] |-> (pat_o == state_o));

endmodule

// File: tb/bs_lfsr_gen_bench.sv
module bs_lfsr_gen_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        en, load;
  logic [15:0] seed;
  logic [15:0] pat16, st16;
  logic        en8, load8;
  logic [7:0]  seed8;
  logic [7:0]  pat8, st8;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;  // 50 MHz

  bs_lfsr_gen u_bs_lfsr_gen (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
    .pat_o(pat16), .state_o(st16)
  );

  bs_lfsr_gen #(.WIDTH(8), .TAPS(8'h71), .INIT(8'h01)) u_small (
    .clk(clk), .rst(rst), .en(en8), .load(load8), .seed(seed8),
    .pat_o(pat8), .state_o(st8)
  );

  localparam logic [15:0] T16 = 16'h6801;
  localparam logic [15:0] I16 = 16'hACE1;

  function automatic logic [15:0] m_step(logic [15:0] s, int w, logic [15:0] taps);
    logic [15:0] mask;
    logic [15:0] r;
    mask = 16'((32'h1 << w) - 1);
    r = (s << 1) & mask;
    if (s[w-1]) r = r ^ taps;
    return r;
  endfunction

  function automatic logic [15:0] m_swap(logic [15:0] s, int w);
    logic [15:0] r;
    r = s;
    if (!s[w-1])
      for (int k = 0; 2*k+1 < w-1; k++) begin
        r[2*k]   = s[2*k+1];
        r[2*k+1] = s[2*k];
      end
    return r;
  endfunction

  function automatic logic [15:0] m_next(logic [15:0] s, logic e, logic l, logic [15:0] sd);
    if (l) return (sd == 16'h0) ? I16 : sd;
    if (e) return m_step(s, 16, T16);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] m;
    int          bad;
    logic [15:0] bad_act, bad_exp;
    int          period;
    longint      tr_pat, tr_raw;
    logic [15:0] prev_p, prev_s;
    int          hits [0:255];
    int          miss;

    void'($urandom(32'd20240611));
    rst = 1'b1; en = 1'b0; load = 1'b0; seed = '0;
    en8 = 1'b0; load8 = 1'b0; seed8 = '0;
    @(negedge clk);
    repeat (3) tick();

    // R1 reset values
    chk(st16 == I16, "R1 state", st16, I16);
    chk(pat16 == m_swap(I16, 16), "R1 pattern", pat16, m_swap(I16, 16));
    chk({8'h0, pat8} == m_swap(16'h0001, 8), "R1 small pattern (swapped)", {8'h0, pat8}, m_swap(16'h0001, 8));

    rst = 1'b0;
    m = I16;
    repeat (4) tick();
    // R3 hold with en and load low
    chk(st16 == I16 && pat16 == m_swap(I16, 16), "R3 hold", st16, I16);

    // R4 + R6 directed load with top bit clear
    load = 1'b1; seed = 16'h1234;
    tick();
    load = 1'b0;
    chk(st16 == 16'h1234, "R4 load", st16, 16'h1234);
    chk(pat16 == m_swap(16'h1234, 16), "R6 swapped pattern", pat16, m_swap(16'h1234, 16));

    // R5 zero seed replaced by INIT
    load = 1'b1; seed = 16'h0000;
    tick();
    load = 1'b0;
    chk(st16 == I16, "R5 zero seed", st16, I16);

    // R4 load wins over en; R7 top bit set passes through
    load = 1'b1; en = 1'b1; seed = 16'h8001;
    tick();
    load = 1'b0; en = 1'b0;
    chk(st16 == 16'h8001, "R4 load priority", st16, 16'h8001);
    chk(pat16 == 16'h8001, "R7 pass-through", pat16, 16'h8001);

    // R2 single step from 8001: top bit set, taps applied
    en = 1'b1;
    tick();
    en = 1'b0;
    chk(st16 == m_step(16'h8001, 16, T16), "R2 step", st16, m_step(16'h8001, 16, T16));
    m = st16;

    // Random stimulus against the model (R2 R3 R4 R5 R6 R7)
    bad = 0; bad_act = '0; bad_exp = '0;
    for (int i = 0; i < 3000; i++) begin
      en   = 1'($urandom_range(0, 3) != 0);
      load = 1'($urandom_range(0, 15) == 0);
      seed = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
      m = m_next(m, en, load, seed);
      tick();
      if (st16 !== m || pat16 !== m_swap(m, 16)) begin
        if (bad == 0) begin bad_act = st16; bad_exp = m; end
        bad++;
      end
    end
    en = 1'b0; load = 1'b0;
    chk(bad == 0, "R2 R3 R4 R5 R6 R7 random run", bad_act, bad_exp);

    // Full period of the 16-bit instance (R8, R10, R2, R6)
    load = 1'b1; seed = I16;
    tick();
    load = 1'b0; en = 1'b1;
    m = I16; prev_p = pat16; prev_s = st16;
    period = 0; tr_pat = 0; tr_raw = 0; bad = 0;
    for (int i = 0; i < 70000; i++) begin
      tick();
      period++;
      m = m_step(m, 16, T16);
      if (st16 !== m || pat16 !== m_swap(m, 16)) begin
        if (bad == 0) begin bad_act = pat16; bad_exp = m_swap(m, 16); end
        bad++;
      end
      tr_pat += $countones(pat16 ^ prev_p);
      tr_raw += $countones(st16 ^ prev_s);
      prev_p = pat16; prev_s = st16;
      if (st16 == I16) break;
    end
    en = 1'b0;
    chk(bad == 0, "R2 R6 full-period model", bad_act, bad_exp);
    chk(period == 65535, "R8 period", 16'(period), 16'hFFFF);
    chk(tr_pat < tr_raw, "R10 fewer output toggles", 16'(tr_pat / 4), 16'(tr_raw / 4));

    // Exhaustive coverage on the 8-bit instance (R9, R8)
    for (int v = 0; v < 256; v++) hits[v] = 0;
    en8 = 1'b1;
    for (int i = 0; i < 255; i++) begin
      tick();
      hits[pat8]++;
    end
    en8 = 1'b0;
    miss = 0;
    for (int v = 1; v < 256; v++) if (hits[v] != 1) miss++;
    chk(miss == 0, "R9 each non-zero vector once", 16'(miss), 16'h0);
    chk(hits[0] == 0, "R9 zero never output", 16'(hits[0]), 16'h0);
    chk(st8 == 8'h01, "R8 small period", {8'h0, st8}, 16'h0001);

    // R3 hold on the small instance, then R5 zero seed there
    tick();
    chk(st8 == 8'h01, "R3 small hold", {8'h0, st8}, 16'h0001);
    load8 = 1'b1; seed8 = 8'h00;
    tick();
    load8 = 1'b0;
    chk(st8 == 8'h01 && pat8 == 8'h02, "R5 small zero seed", {8'h0, pat8}, 16'h0002);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule